// File: doc/BRIEF.md
# Raster Timing Generator

This block counts master clocks to produce the horizontal and vertical raster position of a console video system. From those counts it derives the horizontal and vertical blanking flags, a field parity bit and a per-line window during which the processor side is held off so that dynamic memory can be refreshed. That refresh hold outranks every other bus user, including block transfers, so downstream arbitration treats it as absolute.

The frame shape follows four static mode inputs. A 60 Hz or 50 Hz line count is chosen, interlace adds one line to the even field, and overscan moves the start of vertical blanking down. The refresh window sits at one fixed column, or, in the later variant, moves between two columns on alternate lines. In 60 Hz non-interlaced operation one line of the odd field is four clocks shorter than the others, whatever the video output is doing. The mode inputs are meant to be set while reset is held.

Top module: `raster_timing`

## Requirements
- R1: While reset is held, hcount, vcount and field read 0.
- R2: hcount rises by one each clock from 0 to LINE_CLKS-1 (1364 clocks per line), then returns to 0 as vcount advances by one.
- R3: With region_50=0, interlace_en=0 and field=1, line SHORT_LINE (240) lasts LINE_CLKS-SHORT_CUT clocks (1360), ending at hcount 1359.
- R4: Line SHORT_LINE has full length whenever region_50=1, interlace_en=1 or field=0.
- R5: A field has LINES_60 (262) lines when region_50=0 and LINES_50 (312) when region_50=1; with interlace_en=1 the field=0 field has one more line.
- R6: field toggles exactly when vcount wraps to 0, and never at any other time.
- R7: hblank is high for hcount below 4 and from hcount 1096 through the last clock of the line, and low otherwise.
- R8: vblank is high from line 225 to the end of the field, or from line 240 when overscan_en=1, and low otherwise.
- R9: With refresh_alt=0, refresh_stall is high for exactly the 40 clocks starting at hcount 530 on every line.
- R10: With refresh_alt=1, the 40-clock window starts at 538 on line 0 of each field and switches between 538 and 534 from one line to the next.
- R11: With refresh_alt=1, the shortened line of R3 uses the same window start as the line after it, and the alternation then goes on from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| region_50 | input | 1 | 1 selects the 50 Hz line count, 0 the 60 Hz count |
| interlace_en | input | 1 | Adds a line to the even field and disables the short line |
| overscan_en | input | 1 | Starts vertical blanking at the later line |
| refresh_alt | input | 1 | 1 selects the alternating refresh column, 0 the fixed one |
| hcount | output | $clog2(LINE_CLKS) | Master clock position within the line |
| vcount | output | $clog2(LINES_50+1) | Line number within the field |
| field | output | 1 | Field parity, 1 for the odd field |
| hblank | output | 1 | Horizontal blanking |
| vblank | output | 1 | Vertical blanking |
| refresh_stall | output | 1 | Refresh window that holds off the processor side |

## Verification
The bench builds the generator with a scaled-down raster: 64 clocks per line, 26 or 31 lines per field, the short line at 23, blanking from column 52 and lines 20 or 23, and a 6-clock refresh window at column 30 or alternating between 34 and 32. Those values keep the cut of four clocks and every rule linking lines to fields, so each field of all sixteen mode combinations, including the odd field that holds the short line and the interlaced even field with its extra line, fits in a few thousand clocks. A cycle-by-cycle reference model in the bench then follows every output across two whole fields per mode.

// File: rtl/raster_timing.sv
module raster_timing #(
  parameter int LINE_CLKS    = 1364,
  parameter int SHORT_CUT    = 4,
  parameter int LINES_60     = 262,
  parameter int LINES_50     = 312,
  parameter int SHORT_LINE   = 240,
  parameter int HBL_LEAD     = 4,
  parameter int HBL_START    = 1096,
  parameter int VBL_START    = 225,
  parameter int VBL_START_OS = 240,
  parameter int REF_LEN      = 40,
  parameter int REF_FIXED    = 530,
  parameter int REF_ALT0     = 538,
  parameter int REF_ALT1     = 534,
  localparam int HW = $clog2(LINE_CLKS),
  localparam int VW = $clog2(LINES_50 + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          region_50,
  input  logic          interlace_en,
  input  logic          overscan_en,
  input  logic          refresh_alt,
  output logic [HW-1:0] hcount,
  output logic [VW-1:0] vcount,
  output logic          field,
  output logic          hblank,
  output logic          vblank,
  output logic          refresh_stall
);

  localparam logic [HW-1:0] H_LAST       = HW'(LINE_CLKS - 1);
  localparam logic [HW-1:0] H_SHORT_LAST = HW'(LINE_CLKS - 1 - SHORT_CUT);
  localparam logic [HW-1:0] HB_LEAD      = HW'(HBL_LEAD);
  localparam logic [HW-1:0] HB_START     = HW'(HBL_START);
  localparam logic [HW-1:0] RF_FIX_S     = HW'(REF_FIXED);
  localparam logic [HW-1:0] RF_FIX_E     = HW'(REF_FIXED + REF_LEN);
  localparam logic [HW-1:0] RF_A0_S      = HW'(REF_ALT0);
  localparam logic [HW-1:0] RF_A0_E      = HW'(REF_ALT0 + REF_LEN);
  localparam logic [HW-1:0] RF_A1_S      = HW'(REF_ALT1);
  localparam logic [HW-1:0] RF_A1_E      = HW'(REF_ALT1 + REF_LEN);
  localparam logic [VW-1:0] V60_LAST     = VW'(LINES_60 - 1);
  localparam logic [VW-1:0] V60_LONG     = VW'(LINES_60);
  localparam logic [VW-1:0] V50_LAST     = VW'(LINES_50 - 1);
  localparam logic [VW-1:0] V50_LONG     = VW'(LINES_50);
  localparam logic [VW-1:0] V_SHORT      = VW'(SHORT_LINE);
  localparam logic [VW-1:0] VB_START     = VW'(VBL_START);
  localparam logic [VW-1:0] VB_START_OS  = VW'(VBL_START_OS);

  logic          ref_ph;
  logic          short_line, extra_line, line_end, field_end;
  logic [HW-1:0] h_last, rf_s, rf_e;
  logic [VW-1:0] v_last;

  assign short_line = !region_50 && !interlace_en && field && (vcount == V_SHORT);
  assign extra_line = interlace_en && !field;
  assign h_last     = short_line ? H_SHORT_LAST : H_LAST;
  assign v_last     = region_50 ? (extra_line ? V50_LONG : V50_LAST)
                                : (extra_line ? V60_LONG : V60_LAST);
  assign line_end   = hcount >= h_last;
  assign field_end  = line_end && (vcount >= v_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcount <= '0;
      vcount <= '0;
      field  <= 1'b0;
      ref_ph <= 1'b0;
    end else if (field_end) begin
      hcount <= '0;
      vcount <= '0;
      field  <= ~field;
      ref_ph <= 1'b0;
    end else if (line_end) begin
      hcount <= '0;
      vcount <= vcount + 1'b1;
      ref_ph <= short_line ? ref_ph : ~ref_ph;
    end else begin
      hcount <= hcount + 1'b1;
    end
  end

  assign rf_s = !refresh_alt ? RF_FIX_S : (ref_ph ? RF_A1_S : RF_A0_S);
  assign rf_e = !refresh_alt ? RF_FIX_E : (ref_ph ? RF_A1_E : RF_A0_E);

  assign refresh_stall = (hcount >= rf_s) && (hcount < rf_e);
  assign hblank        = (hcount < HB_LEAD) || (hcount >= HB_START);
  assign vblank        = vcount >= (overscan_en ? VB_START_OS : VB_START);

endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
  parameter int HW         = 11,
  parameter int VW         = 9,
  parameter int LINE_CLKS  = 1364,
  parameter int SHORT_CUT  = 4,
  parameter int SHORT_LINE = 240,
  parameter int HBL_LEAD   = 4,
  parameter int VBL_START  = 225,
  parameter int REF_LEN    = 40,
  parameter int REF_FIXED  = 530
) (
  input logic          clk,
  input logic          rst_n,
  input logic          region_50,
  input logic          interlace_en,
  input logic          refresh_alt,
  input logic [HW-1:0] hcount,
  input logic [VW-1:0] vcount,
  input logic          field,
  input logic          hblank,
  input logic          vblank,
  input logic          refresh_stall
);

  localparam logic [HW-1:0] C_SHORT_LAST = HW'(LINE_CLKS - 1 - SHORT_CUT);
  localparam logic [HW-1:0] C_AFTER_CUT  = HW'(LINE_CLKS - SHORT_CUT);
  localparam logic [HW-1:0] C_LEAD       = HW'(HBL_LEAD);
  localparam logic [HW-1:0] C_RF_S       = HW'(REF_FIXED);
  localparam logic [HW-1:0] C_RF_E       = HW'(REF_FIXED + REF_LEN);
  localparam logic [VW-1:0] C_SHORT_V    = VW'(SHORT_LINE);
  localparam logic [VW-1:0] C_VB         = VW'(VBL_START);

  AST_H_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (hcount != '0) |-> (hcount == $past(hcount) + 1'b1)); // R2
  AST_V_AT_LINE_START: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vcount) |-> (hcount == '0)); // R2
  AST_FIELD_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(field) |-> (vcount == '0 && hcount == '0)); // R6
  AST_SHORT_LINE_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (!region_50 && !interlace_en && field && vcount == C_SHORT_V && hcount == C_SHORT_LAST)
      |=> (hcount == '0)); // R3
  AST_NO_CUT_50HZ: assert property (@(posedge clk) disable iff (!rst_n)
    (region_50 && hcount == C_SHORT_LAST) |=> (hcount == C_AFTER_CUT)); // R4
  AST_HBLANK_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (hcount < C_LEAD) |-> hblank); // R7
  AST_VBLANK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    vblank |-> (vcount >= C_VB)); // R8
  AST_STALL_FIXED_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_stall && !refresh_alt) |-> (hcount >= C_RF_S && hcount < C_RF_E)); // R9

endmodule

bind raster_timing raster_timing_chk #(
  .HW(HW), .VW(VW), .LINE_CLKS(LINE_CLKS), .SHORT_CUT(SHORT_CUT),
  .SHORT_LINE(SHORT_LINE), .HBL_LEAD(HBL_LEAD), .VBL_START(VBL_START),
  .REF_LEN(REF_LEN), .REF_FIXED(REF_FIXED)
) u_chk (
  .clk(clk), .rst_n(rst_n), .region_50(region_50), .interlace_en(interlace_en),
  .refresh_alt(refresh_alt), .hcount(hcount), .vcount(vcount), .field(field),
  .hblank(hblank), .vblank(vblank), .refresh_stall(refresh_stall)
);

// File: tb/raster_timing_bench.sv
module raster_timing_bench;
  localparam int LC = 64, SC = 4, L60 = 26, L50 = 31, SL = 23;
  localparam int HL = 4, HS = 52, VS = 20, VSO = 23;
  localparam int RL = 6, RF = 30, RA0 = 34, RA1 = 32;
  localparam int HW = $clog2(LC), VW = $clog2(L50 + 1);

  logic clk = 0, rst_n = 0;
  logic region_50 = 0, interlace_en = 0, overscan_en = 0, refresh_alt = 0;
  logic [HW-1:0] hcount;
  logic [VW-1:0] vcount;
  logic field, hblank, vblank, refresh_stall;

  int errors = 0, checks = 0;
  int mh, mv, mf, mp;
  bit done = 0;

  always #4 clk = ~clk;

  raster_timing #(
    .LINE_CLKS(LC), .SHORT_CUT(SC), .LINES_60(L60), .LINES_50(L50), .SHORT_LINE(SL),
    .HBL_LEAD(HL), .HBL_START(HS), .VBL_START(VS), .VBL_START_OS(VSO),
    .REF_LEN(RL), .REF_FIXED(RF), .REF_ALT0(RA0), .REF_ALT1(RA1)
  ) u_raster_timing (
    .clk(clk), .rst_n(rst_n), .region_50(region_50), .interlace_en(interlace_en),
    .overscan_en(overscan_en), .refresh_alt(refresh_alt), .hcount(hcount),
    .vcount(vcount), .field(field), .hblank(hblank), .vblank(vblank),
    .refresh_stall(refresh_stall)
  );

  function automatic bit is_short(int v, int f);
    return !region_50 && !interlace_en && f == 1 && v == SL;
  endfunction

  function automatic int line_last(int v, int f);
    return is_short(v, f) ? LC - 1 - SC : LC - 1;
  endfunction

  function automatic int field_last(int f);
    return (region_50 ? L50 : L60) - 1 + ((interlace_en && f == 0) ? 1 : 0);
  endfunction

  function automatic int stall_start(int p);
    if (!refresh_alt) return RF;
    return p ? RA1 : RA0;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (h=%0d v=%0d f=%0d)", tag, act, exp, mh, mv, mf);
    end
  endtask

  task automatic step();
    bit s;
    s = is_short(mv, mf);
    if (mh >= line_last(mv, mf)) begin
      mh = 0;
      if (mv >= field_last(mf)) begin
        mv = 0; mf ^= 1; mp = 0;
      end else begin
        mv++;
        if (!s) mp ^= 1;
      end
    end else begin
      mh++;
    end
  endtask

  task automatic compare();
    string htag, stag;
    int st;
    bit eh, ev, es;
    htag = is_short(mv, mf) ? "R3" : (mv == SL ? "R4" : "R2");
    check(int'(hcount) == mh, htag, int'(hcount), mh);
    check(int'(vcount) == mv, "R5", int'(vcount), mv);
    check(int'(field) == mf, "R6", int'(field), mf);
    eh = (mh < HL) || (mh >= HS);
    check(hblank == eh, "R7", int'(hblank), int'(eh));
    ev = mv >= (overscan_en ? VSO : VS);
    check(vblank == ev, "R8", int'(vblank), int'(ev));
    st = stall_start(mp);
    es = (mh >= st) && (mh < st + RL);
    if (!refresh_alt) stag = "R9";
    else if (!region_50 && !interlace_en && (mv == SL || mv == SL + 1)) stag = "R11";
    else stag = "R10";
    check(refresh_stall == es, stag, int'(refresh_stall), int'(es));
  endtask

  task automatic run_mode(logic [3:0] cfg, int cycles);
    rst_n = 0;
    region_50 = cfg[0]; interlace_en = cfg[1]; overscan_en = cfg[2]; refresh_alt = cfg[3];
    repeat (3) @(negedge clk);
    check(hcount == '0, "R1", int'(hcount), 0);
    check(vcount == '0, "R1", int'(vcount), 0);
    check(field == 1'b0, "R1", int'(field), 0);
    mh = 0; mv = 0; mf = 0; mp = 0;
    rst_n = 1;
    repeat (cycles) begin
      @(negedge clk);
      step();
      compare();
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    for (int c = 0; c < 16; c++) run_mode(4'(c), 4200);
    for (int k = 0; k < 8; k++) run_mode(4'($urandom % 16), 1000 + int'($urandom % 4000));
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule